// File: doc/BRIEF.md
# Serial Divide-Ratio Loader

This block takes a three-wire serial stream (serial clock, serial data and load-enable) and turns it into the parameter words that program a frequency synthesizer's counters. Bits enter a shift register one per rising edge of the serial clock, least significant bit first. The last bit of every word selects its destination. A high bit selects the reference holding latch, which keeps a 14-bit reference count and a prescaler-select bit. A low bit selects the divider holding latch, which keeps a 7-bit swallow count and an 11-bit main count.

All three serial pins are synchronized into the system clock domain. Serial clock edges are detected there, so no flop is clocked from a pin. A rising edge of load-enable commits the shift register to the selected latch, and that latch's update strobe pulses for one system cycle. A word outside its legal range is refused: the latch keeps its old contents and an error pulse is raised in place of the strobe. The downstream counters reload from the latches when they next reach terminal count.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset the reference count is 8, the prescaler-select bit is 0, the swallow count is 0 and the main count is 16. No strobe and no error pulse is active.
- R2: One bit is taken per rising serial clock edge, least significant bit first. A 16-bit reference word is sent as reference count bits 0..13, then the prescaler-select bit, then the control bit. A 19-bit divider word is sent as swallow bits 0..6, then main count bits 0..10, then the control bit.
- R3: A load with control bit 1 writes the reference count and prescaler-select bit and leaves the divider latch unchanged.
- R4: A load with control bit 0 writes the swallow and main counts and leaves the reference latch unchanged.
- R5: Each rising edge of load-enable performs exactly one transfer, and the written latch's strobe is high for exactly one system cycle. Holding load-enable high causes no further transfer.
- R6: A reference count below 8 is refused. The reference latch keeps its value, no strobe fires and the error pulse fires. Values of 8 and 16383 are accepted.
- R7: A main count below 16 is refused in the same way. A main count of 16 is accepted.
- R8: A swallow count not smaller than the main count is refused in the same way. A swallow count of one less than the main count is accepted.
- R9: Serial clock edges without a load-enable edge leave every output unchanged.
- R10: Only the most recent bits decide a word. Bits shifted in before the final 16 or 19 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_data | input | 1 | Serial data pin, asynchronous |
| ser_load | input | 1 | Load-enable pin, asynchronous, active high |
| ref_count | output | 14 | Latched reference divide count |
| pre_sel | output | 1 | Latched prescaler-select bit |
| swallow | output | 7 | Latched swallow count |
| main_count | output | 11 | Latched main divide count |
| ref_upd | output | 1 | One-cycle strobe when the reference latch is written |
| div_upd | output | 1 | One-cycle strobe when the divider latch is written |
| ld_err | output | 1 | One-cycle pulse when a load is refused |

## Verification
The bench sends words with the range limits on both sides: 7 and 8 for the reference count, 15 and 16 for the main count, and a swallow count equal to the main count and one below it. A design with an off-by-one limit either accepts a bad value or refuses a good one. The bench also holds load-enable high for a long time to catch a design that reloads on a level instead of an edge. It shifts full words with no load to catch a design that writes while shifting. It puts junk bits ahead of a word, and it sends a short word after a long one, which shows a design that reads fields from the wrong end of the shift register. After every load the bench checks that the other latch is unchanged, which catches a wrong routing on the control bit.

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int REF_W    = 14,
  parameter int SWAL_W   = 7,
  parameter int MAIN_W   = 11,
  parameter int SYNC_N   = 2,
  parameter int REF_MIN  = 8,
  parameter int MAIN_MIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_count,
  output logic              pre_sel,
  output logic [SWAL_W-1:0] swallow,
  output logic [MAIN_W-1:0] main_count,
  output logic              ref_upd,
  output logic              div_upd,
  output logic              ld_err
);
  localparam int SR_W = SWAL_W + MAIN_W + 1;
  localparam logic [REF_W-1:0]  REF_LIM  = REF_W'(REF_MIN);
  localparam logic [MAIN_W-1:0] MAIN_LIM = MAIN_W'(MAIN_MIN);

  logic [SYNC_N-1:0] clk_sy, dat_sy, le_sy;
  logic              clk_prev, le_prev;
  logic [SR_W-1:0]   sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sy <= '0; dat_sy <= '0; le_sy <= '0;
      clk_prev <= 1'b0; le_prev <= 1'b0;
    end else begin
      clk_sy   <= {clk_sy[SYNC_N-2:0], ser_clk};
      dat_sy   <= {dat_sy[SYNC_N-2:0], ser_data};
      le_sy    <= {le_sy[SYNC_N-2:0], ser_load};
      clk_prev <= clk_sy[SYNC_N-1];
      le_prev  <= le_sy[SYNC_N-1];
    end

  wire clk_rise = clk_sy[SYNC_N-1] & ~clk_prev;
  wire le_rise  = le_sy[SYNC_N-1] & ~le_prev;

  // Newest bit enters at the top, so the control bit always lands in sr[SR_W-1].
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         sr <= '0;
    else if (clk_rise)  sr <= {dat_sy[SYNC_N-1], sr[SR_W-1:1]};

  wire                ctrl   = sr[SR_W-1];
  wire                n_pre  = sr[SR_W-2];
  wire [REF_W-1:0]    n_ref  = sr[SR_W-3 -: REF_W];
  wire [MAIN_W-1:0]   n_main = sr[SR_W-2 -: MAIN_W];
  wire [SWAL_W-1:0]   n_swal = sr[SWAL_W-1:0];
  wire ref_ok = n_ref >= REF_LIM;
  wire div_ok = (n_main >= MAIN_LIM) && (MAIN_W'(n_swal) < n_main);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_count  <= REF_LIM;
      pre_sel    <= 1'b0;
      swallow    <= '0;
      main_count <= MAIN_LIM;
      ref_upd    <= 1'b0;
      div_upd    <= 1'b0;
      ld_err     <= 1'b0;
    end else begin
      ref_upd <= 1'b0;
      div_upd <= 1'b0;
      ld_err  <= 1'b0;
      if (le_rise) begin
        if (ctrl) begin
          if (ref_ok) begin
            ref_count <= n_ref;
            pre_sel   <= n_pre;
            ref_upd   <= 1'b1;
          end else ld_err <= 1'b1;
        end else begin
          if (div_ok) begin
            swallow    <= n_swal;
            main_count <= n_main;
            div_upd    <= 1'b1;
          end else ld_err <= 1'b1;
        end
      end
    end

  p_ref_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_upd |-> ($stable(ref_count) && $stable(pre_sel)));
  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_upd |-> ($stable(main_count) && $stable(swallow)));
  p_ref_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);
  p_div_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd |=> !div_upd);
  p_ref_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_count >= REF_LIM);
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err |-> (!ref_upd && !div_upd));
  p_main_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    main_count >= MAIN_LIM);
  p_swal_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
    MAIN_W'(swallow) < main_count);
endmodule

// File: tb/synth_serial_loader_bench.sv
`timescale 1ns/1ps
module synth_serial_loader_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_count;
  logic        pre_sel;
  logic [6:0]  swallow;
  logic [10:0] main_count;
  logic        ref_upd, div_upd, ld_err;

  synth_serial_loader u_synth_serial_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ref_count(ref_count), .pre_sel(pre_sel),
    .swallow(swallow), .main_count(main_count), .ref_upd(ref_upd),
    .div_upd(div_upd), .ld_err(ld_err));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int n_ref = 0, n_div = 0, n_err = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (ref_upd) n_ref++;
    if (div_upd) n_div++;
    if (ld_err)  n_err++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [18:0] w, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_data = w[i];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse_load(int hold);
    @(negedge clk); ser_load = 1'b1;
    repeat (hold) @(negedge clk); ser_load = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_ref(int r, bit s);
    send_bits({3'b0, 1'b1, s, 14'(r)}, 16);
  endtask

  task automatic send_div(int m, int s);
    send_bits({1'b0, 11'(m), 7'(s)}, 19);
  endtask

  task automatic expect_state(string req, int r, int p, int m, int s);
    check(req, ref_count, r);
    check(req, pre_sel, p);
    check(req, main_count, m);
    check(req, swallow, s);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_state("R1", 8, 0, 16, 0);
    check("R1", ref_upd + div_upd + ld_err, 0);
  endtask

  task automatic t_no_load();
    int r0 = n_ref, d0 = n_div;
    send_ref(1234, 1'b1);
    repeat (10) @(negedge clk);
    expect_state("R9", 8, 0, 16, 0);
    check("R9", n_ref - r0 + n_div - d0, 0);
  endtask

  task automatic t_ref_load();
    int r0 = n_ref, d0 = n_div;
    send_ref(1000, 1'b1);
    pulse_load(8);
    expect_state("R3", 1000, 1, 16, 0);
    check("R5", n_ref - r0, 1);
    check("R3", n_div - d0, 0);
  endtask

  task automatic t_div_load();
    int r0 = n_ref, d0 = n_div;
    send_div(500, 100);
    pulse_load(8);
    expect_state("R4", 1000, 1, 500, 100);
    check("R5", n_div - d0, 1);
    check("R4", n_ref - r0, 0);
  endtask

  task automatic t_long_hold();
    int r0 = n_ref, d0 = n_div;
    send_ref(2000, 1'b0);
    pulse_load(60);
    check("R5", n_ref - r0, 1);
    check("R5", n_div - d0, 0);
    check("R5", ref_count, 2000);
  endtask

  task automatic t_ref_range();
    int r0 = n_ref, e0 = n_err;
    send_ref(7, 1'b1);
    pulse_load(8);
    check("R6", ref_count, 2000);
    check("R6", pre_sel, 0);
    check("R6", n_err - e0, 1);
    check("R6", n_ref - r0, 0);
    send_ref(8, 1'b1);
    pulse_load(8);
    check("R6", ref_count, 8);
    send_ref(16383, 1'b0);
    pulse_load(8);
    check("R6", ref_count, 16383);
    check("R6", n_ref - r0, 2);
  endtask

  task automatic t_main_range();
    int d0 = n_div, e0 = n_err;
    send_div(15, 0);
    pulse_load(8);
    check("R7", main_count, 500);
    check("R7", n_err - e0, 1);
    send_div(16, 15);
    pulse_load(8);
    check("R7", main_count, 16);
    check("R7", swallow, 15);
    check("R7", n_div - d0, 1);
  endtask

  task automatic t_swallow_order();
    int d0 = n_div, e0 = n_err;
    send_div(100, 100);
    pulse_load(8);
    check("R8", main_count, 16);
    check("R8", swallow, 15);
    check("R8", n_err - e0, 1);
    send_div(100, 99);
    pulse_load(8);
    check("R8", main_count, 100);
    check("R8", swallow, 99);
    check("R8", n_div - d0, 1);
  endtask

  task automatic t_stale_bits();
    send_bits(19'h7, 3);
    send_div(1027, 85);
    pulse_load(8);
    check("R10", main_count, 1027);
    check("R2", swallow, 85);
    send_div(2047, 127);
    send_ref(4660, 1'b0);
    pulse_load(8);
    check("R10", ref_count, 4660);
    check("R10", pre_sel, 0);
    check("R10", main_count, 1027);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_no_load();
    t_ref_load();
    t_div_load();
    t_long_hold();
    t_ref_range();
    t_main_range();
    t_swallow_order();
    t_stale_bits();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule